// File: doc/BRIEF.md
# Occupancy-Driven Ring Rate Controller

This block sets the forwarding rate of one ring of an on-chip interconnect so that the ring runs fast only when its buffers need it. It watches the fill levels of the ring's FIFOs and records the highest level seen during a fixed evaluation window. At the end of each window it moves a clock-enable divisor one step. The divisor shrinks, which speeds the ring up, when the window peak is above a high threshold. It grows, which slows the ring down, when the peak is below a low threshold. Otherwise it stays where it is.

The divisor never drops below a cap divisor, so the ring never runs faster than the base clock divided by that cap. It never rises above a configurable maximum divisor. The block produces a single-cycle enable pulse once every `cur_div` cycles, and the ring's forwarding logic uses that pulse as its qualifier. Every ring has its own instance, and each instance adapts independently of the others.

Top module: `ring_rate_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `cur_div` equals the effective cap divisor (fastest permitted rate) and the enable phase counter is at zero, so the first `ring_en` pulse comes `cur_div` cycles after reset release.
- R2: At the end of a window whose peak occupancy is strictly greater than `hi_thresh`, `cur_div` decreases by exactly one in the next cycle, but never below the effective cap; this takes priority when the low condition also holds.
- R3: At the end of a window whose peak occupancy is strictly below `lo_thresh`, and the high condition does not hold, `cur_div` increases by exactly one in the next cycle, but never above the effective maximum.
- R4: A window peak that is at least `lo_thresh` and at most `hi_thresh` (a peak equal to either threshold included) leaves `cur_div` unchanged.
- R5: The window peak is the maximum over all FIFO lanes and over every cycle of the window, so a one-cycle level in a single lane counts. Lane i occupies `fifo_lvl[i*OCC_W +: OCC_W]`.
- R6: While `cur_div` is unchanged, `ring_en` is high for exactly one cycle in every `cur_div` cycles; with `cur_div` equal to 1 it is high every cycle.
- R7: In the first cycle that shows a new `cur_div`, the enable phase restarts at zero, so the next pulse comes in the cycle that completes `cur_div` cycles counting that first cycle.
- R8: The effective cap is `cap_div`, or 1 when `cap_div` is 0. The effective maximum is `max_div`, or the effective cap when `max_div` is below it. After a configuration change, `cur_div` is brought into that range in the next cycle.
- R9: A window lasts `WIN_LEN` cycles, counted from reset release, and with configuration held `cur_div` changes only in the cycle after a window's last cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_lvl | input | NFIFO*OCC_W | Packed fill levels of the ring FIFOs, lane 0 in the low bits |
| hi_thresh | input | OCC_W | Peak above this speeds the ring up |
| lo_thresh | input | OCC_W | Peak below this slows the ring down |
| cap_div | input | DIV_W | Smallest divisor allowed (sets the speed cap) |
| max_div | input | DIV_W | Largest divisor allowed (sets the slowest rate) |
| ring_en | output | 1 | One-cycle forwarding enable, once every `cur_div` cycles |
| cur_div | output | DIV_W | Divisor currently in force |

## Verification
The bench targets a one-cycle spike in a single lane in the middle of a window. A controller that samples only the window's last cycle, or only lane 0, misses it and holds instead of speeding up. It drives peaks exactly equal to each threshold, which an off-by-one comparison turns into a spurious step. It keeps the high and low conditions saturated long enough to press `cur_div` against both bounds, where a missing guard wraps the divisor or runs past the limit. It also sets a zero cap and a maximum below the cap, where a design that skips the substitution divides by zero or leaves the divisor out of range. On every divisor change it checks pulse placement, which shows a phase counter that is not reloaded, because that fires too early or too late.

// File: rtl/rrc_pkg.sv
`timescale 1ns/1ps
package rrc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_FASTER = 2'd1,
    STEP_SLOWER = 2'd2
  } step_e;

  // Smallest divisor in force: zero would mean "no division", so it becomes 1.
  function automatic int eff_floor(int cap);
    return (cap == 0) ? 1 : cap;
  endfunction

  // Largest divisor in force: never below the floor.
  function automatic int eff_ceil(int cap, int mx);
    int fl;
    fl = eff_floor(cap);
    return (mx < fl) ? fl : mx;
  endfunction

  function automatic int clamp_div(int d, int lo, int hi);
    if (d < lo) return lo;
    if (d > hi) return hi;
    return d;
  endfunction

  // High pressure wins when both conditions hold.
  function automatic step_e pick_step(logic over_hi, logic under_lo);
    if (over_hi)  return STEP_FASTER;
    if (under_lo) return STEP_SLOWER;
    return STEP_HOLD;
  endfunction

endpackage

// File: rtl/rrc_occ_peak.sv
`timescale 1ns/1ps
module rrc_occ_peak #(
  parameter int NFIFO   = 4,
  parameter int OCC_W   = 5,
  parameter int WIN_LEN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFIFO*OCC_W-1:0] fifo_lvl,
  output logic                   win_last,
  output logic [OCC_W-1:0]       win_peak
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [OCC_W-1:0] lane [NFIFO];
  logic [OCC_W-1:0] inst_max;
  logic [OCC_W-1:0] peak_q;
  logic [WIN_W-1:0] win_q;

  for (genvar g = 0; g < NFIFO; g++) begin : g_lane
    assign lane[g] = fifo_lvl[g*OCC_W +: OCC_W];
  end

  always_comb begin
    inst_max = '0;
    for (int i = 0; i < NFIFO; i++) begin
      if (lane[i] > inst_max) inst_max = lane[i];
    end
  end

  assign win_peak = (peak_q > inst_max) ? peak_q : inst_max;
  assign win_last = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      peak_q <= '0;
    end else begin
      win_q  <= win_last ? '0 : win_q + WIN_W'(1);
      peak_q <= win_last ? '0 : win_peak;
    end
  end

endmodule

// File: rtl/rrc_div_ctrl.sv
`timescale 1ns/1ps
module rrc_div_ctrl #(
  parameter int OCC_W = 5,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_last,
  input  logic [OCC_W-1:0] win_peak,
  input  logic [OCC_W-1:0] hi_thresh,
  input  logic [OCC_W-1:0] lo_thresh,
  input  logic [DIV_W-1:0] cap_div,
  input  logic [DIV_W-1:0] max_div,
  output logic [DIV_W-1:0] cur_div,
  output logic             div_chg,
  output logic             win_hi,
  output logic             win_lo
);
  import rrc_pkg::*;

  logic [DIV_W-1:0] floor_d;
  logic [DIV_W-1:0] ceil_d;
  logic [DIV_W-1:0] stepped;
  logic [DIV_W-1:0] nxt;
  logic [DIV_W-1:0] cur_q;
  step_e            step;

  assign floor_d = DIV_W'(eff_floor(int'(cap_div)));
  assign ceil_d  = DIV_W'(eff_ceil(int'(cap_div), int'(max_div)));

  assign win_hi = win_last && (win_peak > hi_thresh);
  assign win_lo = win_last && (win_peak < lo_thresh);
  assign step   = pick_step(win_hi, win_lo);

  always_comb begin
    stepped = cur_q;
    unique case (step)
      STEP_FASTER: if (cur_q > floor_d) stepped = cur_q - DIV_W'(1);
      STEP_SLOWER: if (cur_q < ceil_d)  stepped = cur_q + DIV_W'(1);
      default:     stepped = cur_q;
    endcase
  end

  assign nxt     = DIV_W'(clamp_div(int'(stepped), int'(floor_d), int'(ceil_d)));
  assign div_chg = (nxt != cur_q);
  assign cur_div = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= floor_d;
    else        cur_q <= nxt;
  end

endmodule

// File: rtl/rrc_pulse_gen.sv
`timescale 1ns/1ps
module rrc_pulse_gen #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             reload,
  output logic             ring_en
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;
  logic             wrap;

  assign last_phase = cur_div - DIV_W'(1);
  assign ring_en    = (phase_q == last_phase);
  assign wrap       = (phase_q >= last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (reload) phase_q <= '0;
    else if (wrap)   phase_q <= '0;
    else             phase_q <= phase_q + DIV_W'(1);
  end

endmodule

// File: rtl/ring_rate_ctrl.sv
`timescale 1ns/1ps
module ring_rate_ctrl #(
  parameter int NFIFO   = 4,
  parameter int OCC_W   = 5,
  parameter int DIV_W   = 5,
  parameter int WIN_LEN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFIFO*OCC_W-1:0] fifo_lvl,
  input  logic [OCC_W-1:0]       hi_thresh,
  input  logic [OCC_W-1:0]       lo_thresh,
  input  logic [DIV_W-1:0]       cap_div,
  input  logic [DIV_W-1:0]       max_div,
  output logic                   ring_en,
  output logic [DIV_W-1:0]       cur_div
);
  // Internal events, named for the bound checker.
  logic             win_last;
  logic [OCC_W-1:0] win_peak;
  logic             win_hi;
  logic             win_lo;
  logic             div_chg;

  rrc_occ_peak #(
    .NFIFO(NFIFO), .OCC_W(OCC_W), .WIN_LEN(WIN_LEN)
  ) u_peak (
    .clk(clk), .rst_n(rst_n), .fifo_lvl(fifo_lvl),
    .win_last(win_last), .win_peak(win_peak)
  );

  rrc_div_ctrl #(
    .OCC_W(OCC_W), .DIV_W(DIV_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .win_last(win_last), .win_peak(win_peak),
    .hi_thresh(hi_thresh), .lo_thresh(lo_thresh),
    .cap_div(cap_div), .max_div(max_div),
    .cur_div(cur_div), .div_chg(div_chg), .win_hi(win_hi), .win_lo(win_lo)
  );

  rrc_pulse_gen #(
    .DIV_W(DIV_W)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .cur_div(cur_div), .reload(div_chg),
    .ring_en(ring_en)
  );

endmodule

// File: rtl/rrc_checker.sv
`timescale 1ns/1ps
module rrc_checker #(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cap_div,
  input logic [DIV_W-1:0] max_div,
  input logic [DIV_W-1:0] cur_div,
  input logic             ring_en,
  input logic             win_last,
  input logic             win_hi,
  input logic             win_lo
);
  localparam logic [DIV_W:0] ONE_X = (DIV_W+1)'(1);

  logic [DIV_W-1:0] lo_bound;
  logic [DIV_W-1:0] hi_bound;
  logic [DIV_W-1:0] cap_q;
  logic [DIV_W-1:0] max_q;
  logic             same_q;
  logic             quiet;

  always_comb begin
    lo_bound = (cap_div == '0) ? DIV_W'(1) : cap_div;
    hi_bound = (max_div < lo_bound) ? lo_bound : max_div;
  end

  always_ff @(posedge clk) begin
    cap_q  <= cap_div;
    max_q  <= max_div;
    same_q <= (cap_div == cap_q) && (max_div == max_q);
  end

  // Configuration unchanged for the last two edges.
  assign quiet = same_q && (cap_div == cap_q) && (max_div == max_q);

  // R8
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (cur_div >= lo_bound) && (cur_div <= hi_bound));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (cur_div == $past(cur_div)) ||
              ({1'b0, cur_div} == {1'b0, $past(cur_div)} + ONE_X) ||
              ({1'b0, $past(cur_div)} == {1'b0, cur_div} + ONE_X));

  // R2
  faster_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (cur_div < $past(cur_div))) |-> $past(win_hi));

  // R3
  slower_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && (cur_div > $past(cur_div))) |-> ($past(win_lo) && !$past(win_hi)));

  // R9
  window_cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !$past(win_last)) |-> $stable(cur_div));

  // R6
  en_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_div == DIV_W'(1)) |-> ring_en);

  // R6
  en_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en && (cur_div > DIV_W'(1))) |=> (!ring_en || (cur_div == DIV_W'(1))));

endmodule

bind ring_rate_ctrl rrc_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_div(cap_div), .max_div(max_div),
  .cur_div(cur_div), .ring_en(ring_en), .win_last(win_last),
  .win_hi(win_hi), .win_lo(win_lo)
);

// File: tb/ring_rate_ctrl_tb.sv
`timescale 1ns/1ps
module ring_rate_ctrl_tb;
  localparam int NFIFO = 4;
  localparam int OCC_W = 5;
  localparam int DIV_W = 5;
  localparam int WIN   = 8;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NFIFO*OCC_W-1:0] fifo_lvl = '0;
  logic [OCC_W-1:0]       hi_thresh = '0;
  logic [OCC_W-1:0]       lo_thresh = '0;
  logic [DIV_W-1:0]       cap_div = '0;
  logic [DIV_W-1:0]       max_div = '0;
  logic                   ring_en;
  logic [DIV_W-1:0]       cur_div;

  always #5 clk = ~clk;

  ring_rate_ctrl #(.NFIFO(NFIFO), .OCC_W(OCC_W), .DIV_W(DIV_W), .WIN_LEN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_lvl(fifo_lvl), .hi_thresh(hi_thresh),
    .lo_thresh(lo_thresh), .cap_div(cap_div), .max_div(max_div),
    .ring_en(ring_en), .cur_div(cur_div)
  );

  typedef struct {
    bit    en;
    int    dv;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Reference state, kept from the requirements.
  int m_div, m_ph, m_top, m_win;
  int c_cap, c_max, c_hi, c_lo;

  task automatic apply_cfg(int cap, int mx, int hi, int lo);
    c_cap = cap; c_max = mx; c_hi = hi; c_lo = lo;
    cap_div = DIV_W'(cap); max_div = DIV_W'(mx);
    hi_thresh = OCC_W'(hi); lo_thresh = OCC_W'(lo);
  endtask

  // Advance the reference over one rising edge with the given lane levels.
  task automatic ref_edge(int a, int b, int c, int d);
    int lowest, highest, seen, want;
    lowest  = (c_cap == 0) ? 1 : c_cap;
    highest = (c_max > lowest) ? c_max : lowest;
    seen = m_top;
    if (a > seen) seen = a;
    if (b > seen) seen = b;
    if (c > seen) seen = c;
    if (d > seen) seen = d;
    want = m_div;
    if (m_win == WIN - 1) begin
      if (seen > c_hi)      want = (m_div > lowest)  ? m_div - 1 : m_div;
      else if (seen < c_lo) want = (m_div < highest) ? m_div + 1 : m_div;
    end
    if (want < lowest)  want = lowest;
    if (want > highest) want = highest;
    if (want != m_div)           m_ph = 0;
    else if (m_ph + 1 >= m_div)  m_ph = 0;
    else                         m_ph = m_ph + 1;
    m_top = (m_win == WIN - 1) ? 0 : seen;
    m_win = (m_win == WIN - 1) ? 0 : m_win + 1;
    m_div = want;
  endtask

  // Driver: holds levels for n cycles, queueing what the outputs must show.
  task automatic run(int n, int a, int b, int c, int d, string tag);
    for (int k = 0; k < n; k++) begin
      exp_t it;
      fifo_lvl = {OCC_W'(d), OCC_W'(c), OCC_W'(b), OCC_W'(a)};
      it.en  = (m_ph == m_div - 1);
      it.dv  = m_div;
      it.tag = tag;
      q.push_back(it);
      ref_edge(a, b, c, d);
      @(negedge clk);
    end
  endtask

  // Monitor: compares each queued item away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (ring_en !== it.en || int'(cur_div) != it.dv) begin
          errors++;
          $display("FAIL %s: ring_en=%0b cur_div=%0d expected ring_en=%0b cur_div=%0d",
                   it.tag, ring_en, cur_div, it.en, it.dv);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    apply_cfg(2, 12, 20, 4);
    fifo_lvl = {4{OCC_W'(10)}};
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    m_div = 2; m_ph = 0; m_top = 0; m_win = 0;

    // R1: reset state and first pulse timing.
    run(2, 10, 10, 10, 10, "R1");
    // R4 R6: mid-range levels hold the divisor, pulses every 2 cycles.
    run(22, 10, 10, 10, 10, "R4 R6");
    // R3 R7 R9: empty buffers slow the ring one step per window.
    run(80, 0, 0, 0, 0, "R3 R7 R9");
    run(24, 0, 0, 0, 0, "R3");
    // R5: one-cycle spike on lane 2 mid-window.
    run(3, 10, 10, 10, 10, "R4");
    run(1, 10, 10, 25, 10, "R5");
    run(20, 10, 10, 10, 10, "R5");
    // R2 R7: full buffers speed up to the cap and stay there.
    run(100, 30, 30, 30, 30, "R2 R7");
    // R4: peaks equal to either threshold hold.
    run(16, 20, 20, 20, 20, "R4");
    run(24, 0, 0, 0, 0, "R3");
    run(16, 4, 4, 4, 4, "R4");
    // R8 R6: zero cap acts as 1, enable every cycle at the cap.
    apply_cfg(0, 12, 20, 4);
    run(100, 30, 30, 30, 30, "R8 R6 R2");
    // R8: maximum below cap, divisor forced up to the cap.
    apply_cfg(5, 3, 20, 4);
    run(20, 10, 10, 10, 10, "R8");
    // R2: both conditions true, speed-up wins.
    apply_cfg(2, 12, 2, 8);
    run(40, 5, 5, 5, 5, "R2");
    // R3: climb to the largest representable divisor and saturate.
    apply_cfg(1, 31, 20, 4);
    run(280, 0, 0, 0, 0, "R3 R6");

    repeat (2) @(negedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule